// File: doc/BRIEF.md
# Serial Memory Boot Loader

After a reset, this block fills the bottom of a byte-wide SRAM with a program held in a serial EEPROM, then lets the processor start running. While the copy runs it keeps the CPU in reset and owns the SRAM address and data buses. It opens one continuous read on the EEPROM: chip select goes low, it sends a read opcode and a zero start address, and then it clocks bytes in. Each byte is collected in an 8-bit serial-in, parallel-out register. The register's parallel output is the SRAM write data. An address counter that starts at zero supplies the SRAM address.

A configuration input sets the number of bytes copied. Another input sets the serial-clock prescaler. When the last byte is written, the block raises chip select and turns off its bus drivers. One cycle later it releases the CPU reset, so the processor fetches from address 0. A synchronous reset at any point starts the whole load again.

Top module: `spi_boot_loader`

## Requirements
- R1: While `rst` is high, `cpu_rst_n` is 0, `bus_en` is 1, `spi_cs_n` is 1, `spi_sclk` is 0 and `boot_done` is 0.
- R2: A load with a non-zero length lowers `spi_cs_n` once. The first 24 bits on `spi_mosi`, as captured on rising `spi_sclk` edges, are the opcode 0x03 followed by a 16-bit zero address, most significant bit first. `spi_sclk` is only high while `spi_cs_n` is low.
- R3: Every high phase of `spi_sclk` lasts exactly `sclk_div`+1 clock cycles.
- R4: Each data byte is sampled from `spi_miso` on rising `spi_sclk` edges and assembled most significant bit first.
- R5: A load of length X gives exactly X one-cycle `sram_we` pulses, to addresses 0, 1, ..., X-1 in that order. The data of each pulse is the corresponding received byte, and `bus_en` is 1 during each pulse.
- R6: `sram_addr` and `sram_data` hold the same values in the cycle before a write pulse and in the pulse cycle itself.
- R7: At the end of a load, `spi_cs_n` is 1 and `bus_en` falls at least one cycle before `cpu_rst_n` rises. `sram_addr` and `sram_data` are high-impedance whenever `bus_en` is 0.
- R8: A length of 0 gives no chip-select activity and no writes. `boot_done` is 1 one cycle after reset ends, and `cpu_rst_n` is 1 one cycle after that.
- R9: `boot_done` and `cpu_rst_n` stay 1, and no further writes occur, until the next reset, whatever `boot_len` does.
- R10: A reset in the middle of a load abandons that load. The following load starts again from SRAM address 0 and EEPROM address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; restarts the load |
| boot_len | input | 16 | Number of bytes to copy, captured when the load starts |
| sclk_div | input | 8 | Prescaler setting; each serial clock phase is this value plus 1 cycles |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sclk | output | 1 | EEPROM serial clock, idles low |
| spi_mosi | output | 1 | Opcode and address bits to the EEPROM |
| spi_miso | input | 1 | Data bits from the EEPROM |
| sram_addr | output | 16 | SRAM address; high-impedance when the bus is released |
| sram_data | output | 8 | SRAM write data; high-impedance when the bus is released |
| sram_we | output | 1 | SRAM write strobe, active high for one cycle per byte |
| bus_en | output | 1 | High while the loader drives the SRAM buses |
| cpu_rst_n | output | 1 | CPU reset, active low; released after the copy |
| boot_done | output | 1 | Load finished; held until the next reset |

## Verification
The bench builds the block with its default widths: a 16-bit address, an 8-bit byte and an 8-bit prescaler. At run time it varies the length and prescaler inputs instead. Prescaler settings 0, 1 and 3 cover the shortest possible serial-clock phase, where a bit is sampled one cycle after the falling edge, as well as longer phases. Lengths of 0, 1, 5 and 20 cover the skipped copy, a single byte that is both first and last, and runs of many back-to-back byte writes. A reset in the middle of a load and a hold phase with a changing length input reach the restart and sticky-completion behaviour.

// File: rtl/boot_pkg.sv
`timescale 1ns/1ps
package boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND_CMD,
    ST_SEND_ADDR,
    ST_READ_BYTE,
    ST_WRITE_SRAM,
    ST_DONE
  } boot_state_e;
endpackage

// File: rtl/boot_prescaler.sv
`timescale 1ns/1ps
module boot_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/boot_sipo.sv
`timescale 1ns/1ps
module boot_sipo #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[WIDTH-2:0], din};
  end
endmodule

// File: rtl/boot_addr_ctr.sv
`timescale 1ns/1ps
module boot_addr_ctr #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (inc) q <= q + 1'b1;
  end
endmodule

// File: rtl/spi_boot_loader.sv
`timescale 1ns/1ps
module spi_boot_loader
  import boot_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         DIV_W       = 8,
  parameter int         CMD_W       = 8,
  parameter logic [7:0] READ_OPCODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] boot_len,
  input  logic [DIV_W-1:0]  sclk_div,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_data,
  output logic              sram_we,
  output logic              bus_en,
  output logic              cpu_rst_n,
  output logic              boot_done
);
  localparam int TX_W  = CMD_W + ADDR_W;
  localparam int MAXB  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int BIT_W = $clog2(MAXB);

  function automatic logic is_last_f(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] total);
    return addr == (total - 1'b1);
  endfunction

  function automatic logic field_end_f(input logic [BIT_W-1:0] cnt, input int len);
    return cnt == BIT_W'(len - 1);
  endfunction

  boot_state_e       state_q;
  logic [TX_W-1:0]   tx_q;
  logic [BIT_W-1:0]  bit_q;
  logic [ADDR_W-1:0] total_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              sclk_q, cs_n_q, bus_en_q, cpu_rel_q;

  // Named events, also observed by the checker
  logic serial_run, tick, sclk_rise, sclk_fall, byte_done, last_byte, write_cyc;

  assign serial_run = (state_q == ST_SEND_CMD) || (state_q == ST_SEND_ADDR) ||
                      (state_q == ST_READ_BYTE);
  assign sclk_rise  = tick && !sclk_q;
  assign sclk_fall  = tick && sclk_q;
  assign byte_done  = sclk_fall && (state_q == ST_READ_BYTE) && field_end_f(bit_q, DATA_W);
  assign write_cyc  = (state_q == ST_WRITE_SRAM);
  assign last_byte  = write_cyc && is_last_f(addr_q, total_q);

  boot_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk(clk), .rst(rst), .run(serial_run), .limit(sclk_div), .tick(tick)
  );

  boot_sipo #(.WIDTH(DATA_W)) sipo_i (
    .clk(clk), .rst(rst),
    .shift_en(sclk_rise && (state_q == ST_READ_BYTE)),
    .din(spi_miso), .q(data_q)
  );

  boot_addr_ctr #(.WIDTH(ADDR_W)) actr_i (
    .clk(clk), .rst(rst), .inc(write_cyc), .q(addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      tx_q      <= '0;
      bit_q     <= '0;
      total_q   <= '0;
      sclk_q    <= 1'b0;
      cs_n_q    <= 1'b1;
      bus_en_q  <= 1'b1;
      cpu_rel_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          total_q <= boot_len;
          if (boot_len == '0) begin
            bus_en_q <= 1'b0;
            state_q  <= ST_DONE;
          end else begin
            cs_n_q  <= 1'b0;
            tx_q    <= {READ_OPCODE[CMD_W-1:0], {ADDR_W{1'b0}}};
            bit_q   <= '0;
            state_q <= ST_SEND_CMD;
          end
        end
        ST_SEND_CMD, ST_SEND_ADDR, ST_READ_BYTE: begin
          if (tick) sclk_q <= ~sclk_q;
          if (sclk_fall) begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[TX_W-2:0], 1'b0};
            if (state_q == ST_SEND_CMD && field_end_f(bit_q, CMD_W)) begin
              bit_q   <= '0;
              state_q <= ST_SEND_ADDR;
            end else if (state_q == ST_SEND_ADDR && field_end_f(bit_q, ADDR_W)) begin
              bit_q   <= '0;
              state_q <= ST_READ_BYTE;
            end else if (byte_done) begin
              bit_q   <= '0;
              state_q <= ST_WRITE_SRAM;
            end
          end
        end
        ST_WRITE_SRAM: begin
          if (last_byte) begin
            cs_n_q   <= 1'b1;
            bus_en_q <= 1'b0;
            state_q  <= ST_DONE;
          end else begin
            state_q <= ST_READ_BYTE;
          end
        end
        ST_DONE: cpu_rel_q <= 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = tx_q[TX_W-1];
  assign sram_we   = write_cyc;
  assign bus_en    = bus_en_q;
  assign cpu_rst_n = cpu_rel_q;
  assign boot_done = (state_q == ST_DONE);
  assign sram_addr = bus_en_q ? addr_q : {ADDR_W{1'bz}};
  assign sram_data = bus_en_q ? data_q : {DATA_W{1'bz}};
endmodule

// File: rtl/boot_loader_checker.sv
`timescale 1ns/1ps
module boot_loader_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic              spi_sclk,
  input logic              sram_we,
  input logic              bus_en,
  input logic              cpu_rst_n,
  input logic              boot_done,
  input logic              byte_done,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] data_q
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!cpu_rst_n && bus_en && spi_cs_n && !spi_sclk && !boot_done)); // R1
  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !spi_cs_n); // R2
  AST_BYTE_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> sram_we); // R5
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sram_we |=> !sram_we); // R5
  AST_WE_OWNS_BUS: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> bus_en); // R5
  AST_WE_STABLE: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> ($stable(addr_q) && $stable(data_q))); // R6
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_rst_n) |-> (!bus_en && $past(!bus_en))); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    boot_done |-> (spi_cs_n && !bus_en && !sram_we)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    boot_done |=> (boot_done && $stable(addr_q))); // R9
endmodule

bind spi_boot_loader boot_loader_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
  .sram_we(sram_we), .bus_en(bus_en), .cpu_rst_n(cpu_rst_n),
  .boot_done(boot_done), .byte_done(byte_done), .addr_q(addr_q), .data_q(data_q)
);

// File: tb/spi_boot_loader_tb.sv
`timescale 1ns/1ps
module spi_boot_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] boot_len = 16'd0;
  logic [7:0]  sclk_div = 8'd0;
  logic        miso_r = 1'b0;
  wire         spi_cs_n, spi_sclk, spi_mosi;
  wire  [15:0] sram_addr;
  wire  [7:0]  sram_data;
  wire         sram_we, bus_en, cpu_rst_n, boot_done;

  int nvec = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  spi_boot_loader dut_i (
    .clk(clk), .rst(rst), .boot_len(boot_len), .sclk_div(sclk_div),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(miso_r),
    .sram_addr(sram_addr), .sram_data(sram_data), .sram_we(sram_we),
    .bus_en(bus_en), .cpu_rst_n(cpu_rst_n), .boot_done(boot_done)
  );

  function automatic logic [7:0] rom_byte(input int j);
    return 8'((j * 29 + 90) ^ (j >> 2));
  endfunction

  // EEPROM model: mode 0, bits change after the falling edge
  int          rises = 0;
  int          cs_falls = 0;
  logic [23:0] cmd_word = '0;
  always @(negedge spi_cs_n) begin
    rises = 0; cmd_word = '0; cs_falls++;
  end
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    if (rises < 24) cmd_word = {cmd_word[22:0], spi_mosi};
    rises++;
  end
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0 && rises >= 24) begin
    int idx;
    logic [7:0] b;
    idx = rises - 24;
    b = rom_byte(idx / 8);
    miso_r = b[7 - (idx % 8)];
  end

  // Bus monitor, sampled away from the active edge
  logic [15:0] wr_a [0:63];
  logic [7:0]  wr_d [0:63];
  int n_wr = 0, stab_err = 0, order_err = 0, hi_run = 0, hi_min = 0, hi_max = 0;
  logic [15:0] prev_a = '0;
  logic [7:0]  prev_d = '0;
  logic prev_rel = 1'b0, prev_en = 1'b1;
  always @(negedge clk) if (!rst) begin
    if (sram_we === 1'b1) begin
      if (n_wr < 64) begin wr_a[n_wr] = sram_addr; wr_d[n_wr] = sram_data; end
      if (sram_addr !== prev_a || sram_data !== prev_d) stab_err++;
      n_wr++;
    end
    prev_a = sram_addr; prev_d = sram_data;
    if (spi_sclk === 1'b1) hi_run++;
    else if (hi_run > 0) begin
      if (hi_min == 0 || hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    if (cpu_rst_n === 1'b1 && !prev_rel && prev_en !== 1'b0) order_err++;
    prev_rel = cpu_rst_n; prev_en = bus_en;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_wr = 0; stab_err = 0; order_err = 0; hi_run = 0; hi_min = 0; hi_max = 0;
    cs_falls = 0; cmd_word = '0; prev_rel = 1'b0; prev_en = 1'b1;
  endtask

  task automatic start_load(input int len, input int div);
    @(negedge clk);
    rst = 1'b1; boot_len = 16'(len); sclk_div = 8'(div);
    repeat (3) @(negedge clk);
    clear_logs();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_done(input int limit, output int cycles);
    cycles = 0;
    while (boot_done !== 1'b1 && cycles < limit) begin
      @(negedge clk); cycles++;
    end
    chk(boot_done === 1'b1, "R5", "load finished before timeout", cycles, limit);
  endtask

  task automatic check_load(input int len, input int div);
    int cyc;
    wait_done(20000, cyc);
    repeat (3) @(negedge clk);
    chk(cs_falls == 1, "R2", "chip select falls", cs_falls, 1);
    chk(cmd_word == 24'h030000, "R2", "opcode and address", int'(cmd_word), 24'h030000);
    chk(hi_min == div + 1 && hi_max == div + 1, "R3", "sclk high phase", hi_max, div + 1);
    chk(n_wr == len, "R5", "write pulses", n_wr, len);
    for (int i = 0; i < len && i < 64; i++) begin
      chk(wr_a[i] == 16'(i), "R5", "write address", int'(wr_a[i]), i);
      chk(wr_d[i] == rom_byte(i), "R4", "write data", int'(wr_d[i]), int'(rom_byte(i)));
    end
    chk(stab_err == 0, "R6", "addr/data stable around strobe", stab_err, 0);
    chk(order_err == 0, "R7", "bus released before cpu", order_err, 0);
    chk(spi_cs_n === 1'b1 && bus_en === 1'b0 && cpu_rst_n === 1'b1, "R7",
        "final cs/bus_en/cpu", int'({spi_cs_n, bus_en, cpu_rst_n}), 3'b101);
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(cpu_rst_n === 1'b0 && bus_en === 1'b1 && spi_cs_n === 1'b1 &&
        spi_sclk === 1'b0 && boot_done === 1'b0, "R1", "reset outputs",
        int'({cpu_rst_n, bus_en, spi_cs_n, spi_sclk, boot_done}), 5'b01100);
  endtask

  task automatic t_load(input int len, input int div);
    start_load(len, div);
    check_load(len, div);
  endtask

  task automatic t_zero_len();
    start_load(0, 2);
    @(negedge clk);
    chk(boot_done === 1'b1 && bus_en === 1'b0, "R8", "done one cycle after reset",
        int'({boot_done, bus_en}), 2'b10);
    chk(cpu_rst_n === 1'b0, "R8", "cpu still held on first done cycle", int'(cpu_rst_n), 0);
    @(negedge clk);
    chk(cpu_rst_n === 1'b1, "R8", "cpu released next cycle", int'(cpu_rst_n), 1);
    repeat (20) @(negedge clk);
    chk(cs_falls == 0 && n_wr == 0, "R8", "no serial or SRAM activity", cs_falls + n_wr, 0);
  endtask

  task automatic t_hold();
    start_load(2, 0);
    check_load(2, 0);
    boot_len = 16'd9;
    repeat (100) @(negedge clk);
    chk(boot_done === 1'b1 && cpu_rst_n === 1'b1, "R9", "done held",
        int'({boot_done, cpu_rst_n}), 2'b11);
    chk(n_wr == 2 && spi_cs_n === 1'b1, "R9", "no writes after done", n_wr, 2);
  endtask

  task automatic t_midreset();
    int cyc;
    start_load(6, 1);
    cyc = 0;
    while (n_wr < 2 && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(n_wr >= 2 && boot_done === 1'b0, "R10", "load interrupted in progress", n_wr, 2);
    start_load(3, 1);
    check_load(3, 1);
    chk(wr_a[0] == 16'd0 && wr_d[0] == rom_byte(0), "R10", "restart at address 0",
        int'(wr_a[0]), 0);
  endtask

  initial begin
    #1_500_000;
    nvec++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    t_reset_state();
    t_load(1, 0);
    t_load(5, 3);
    t_load(20, 1);
    t_zero_len();
    t_hold();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule